// File: doc/BRIEF.md
# Legacy Interrupt Map Autodetector

This block sits beside the configuration-write path of a PCI host bridge. It watches the writes that software makes to the interrupt-line byte of each device's configuration header. From the first meaningful value it decides whether the software was built for an old, incorrect interrupt wiring or for the real one. It then steers every slot's four interrupt pins onto four shared level-sensitive output lines to match.

The decision is held in a three-state mode register. It starts out "assume correct", falls into "legacy" or "forced correct" on the first telling write, and stays there until reset. A two-bit strap sets the reset value, so a system that already knows its software can skip the detection. A variant input chooses between two board wirings. In the first wiring the pins are rotated by two positions per slot, and detection is active. In the second wiring the pins are rotated by three positions, and no detection takes place.

Top module: `legacy_irq_autodetect`

## Requirements
- R1: `mode_out` encodes 0 = assume-correct, 1 = legacy, 2 = forced-correct and never shows 3. While `rst` is high the mode is loaded from `mode_strap`, and a strap of 3 loads assume-correct.
- R2: Once the mode is legacy or forced-correct, no config write changes it until the next reset.
- R3: A write is classified only when `cfg_wr_valid` is high, `variant_sel` is 0, the mode is assume-correct and `cfg_wr_addr[7:0]` equals 0x3C. Any other write leaves the mode unchanged.
- R4: The slot of a snooped write is `cfg_wr_addr[15:11]`, and only its two low bits (slot modulo 4) affect classification.
- R5: The classified value is `cfg_wr_data[7:0]`. A value of 27 keeps assume-correct when slot modulo 4 is 2, and selects legacy for any other slot.
- R6: A value equal to 27 + (slot mod 4) or 91 + (slot mod 4) selects legacy. Any other value selects forced-correct.
- R7: In legacy mode the request of pin p (0..3) from any slot drives `irq_out[p]`.
- R8: In any other mode the request of slot s, pin p drives `irq_out[(s+p+2) mod 4]` when `variant_sel` is 0, and `irq_out[(s+p+3) mod 4]` when it is 1. The request of slot s, pin p is `slot_irq_req[4*s+p]`.
- R9: Each output line is the OR of all requests that currently map to it. With no requests, all lines are low.
- R10: A mode change caused by a write is registered at that write's clock edge. From the following cycle it is visible both on `mode_out` and in the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_sel | input | 1 | Board wiring variant: 0 = rotate by 2 with detection, 1 = rotate by 3 |
| mode_strap | input | 2 | Mode value loaded during reset |
| cfg_wr_valid | input | 1 | Config write strobe, one per cycle |
| cfg_wr_addr | input | CFG_AW | Config write address (bits 15:8 hold the device/function number) |
| cfg_wr_data | input | CFG_DW | Config write data |
| slot_irq_req | input | 4*NUM_SLOTS | Level interrupt requests, bit 4*s+p for slot s, pin p |
| irq_out | output | 4 | Shared level interrupt lines |
| mode_out | output | 2 | Current mapping mode |

## Verification
The hardest states to reach are the ones the sticky register locks behind the first telling write. Legacy or forced-correct routing, and the proof that later writes are ignored, can only be observed after a correctly classified write. Every classification outcome is therefore reached in its own reset epoch. The stimulus pulses reset with a chosen strap, then issues carefully ignored writes (wrong offset, strobe low, second variant, the ambiguous value 27 at a slot congruent to 2). After that comes one decisive write, and a walk of single and combined requests across all slots and pins is compared each cycle against a behavioural model.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

    localparam int PINS  = 4;
    localparam int LINES = 4;

    localparam logic [7:0] BASE_LINE   = 8'd27;
    localparam logic [7:0] SHIFTED_ADD = 8'd64;

    typedef enum logic [1:0] {
        MODE_ASSUME_OK = 2'd0,
        MODE_LEGACY    = 2'd1,
        MODE_FORCE_OK  = 2'd2
    } map_mode_e;

    typedef struct packed {
        logic       hit;
        logic [1:0] slot_mod;
        logic [7:0] value;
    } snoop_t;

    function automatic map_mode_e strap_decode(input logic [1:0] strap);
        case (strap)
            2'd1:    return MODE_LEGACY;
            2'd2:    return MODE_FORCE_OK;
            default: return MODE_ASSUME_OK;
        endcase
    endfunction

    function automatic map_mode_e classify(input logic [1:0] slot_mod,
                                           input logic [7:0] value);
        logic [7:0] swz_line;
        logic [7:0] shifted_line;
        swz_line     = BASE_LINE + {6'd0, slot_mod};
        shifted_line = swz_line + SHIFTED_ADD;
        if (value == BASE_LINE) begin
            if (slot_mod == 2'd2) return MODE_ASSUME_OK;
            return MODE_LEGACY;
        end
        if (value == swz_line)     return MODE_LEGACY;
        if (value == shifted_line) return MODE_LEGACY;
        return MODE_FORCE_OK;
    endfunction

    function automatic logic [1:0] route_line(input map_mode_e  mode,
                                              input logic       variant,
                                              input logic [1:0] slot_mod,
                                              input logic [1:0] pin);
        if (mode == MODE_LEGACY) return pin;
        if (variant) return slot_mod + pin + 2'd3;
        return slot_mod + pin + 2'd2;
    endfunction

endpackage

// File: rtl/irqmap_snoop.sv
module irqmap_snoop
    import irqmap_pkg::*;
#(
    parameter int         CFG_AW       = 24,
    parameter int         CFG_DW       = 32,
    parameter logic [7:0] LINE_REG_OFS = 8'h3C
) (
    input  logic              cfg_wr_valid,
    input  logic [CFG_AW-1:0] cfg_wr_addr,
    input  logic [CFG_DW-1:0] cfg_wr_data,
    input  logic              variant_sel,
    output snoop_t            snp
);
    localparam int SLOT_LSB = 11;

    logic offset_match;

    always_comb begin
        offset_match  = (cfg_wr_addr[7:0] == LINE_REG_OFS);
        snp.hit       = cfg_wr_valid && !variant_sel && offset_match;
        snp.slot_mod  = cfg_wr_addr[SLOT_LSB+1:SLOT_LSB];
        snp.value     = cfg_wr_data[7:0];
    end

endmodule

// File: rtl/irqmap_mode_reg.sv
module irqmap_mode_reg
    import irqmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_strap,
    input  snoop_t     snp,
    output map_mode_e  mode
);
    map_mode_e mode_q;
    map_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (snp.hit && mode_q == MODE_ASSUME_OK)
            mode_d = classify(snp.slot_mod, snp.value);
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= strap_decode(mode_strap);
        else     mode_q <= mode_d;
    end

    assign mode = mode_q;

endmodule

// File: rtl/irqmap_router.sv
module irqmap_router
    import irqmap_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  map_mode_e                  mode,
    input  logic                       variant_sel,
    input  logic [NUM_SLOTS*PINS-1:0]  slot_irq_req,
    output logic [LINES-1:0]           irq_out
);
    localparam int REQ_W = NUM_SLOTS * PINS;

    logic [1:0] target [REQ_W];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            assign target[s*PINS+p] = route_line(mode, variant_sel, 2'(s), 2'(p));
        end
    end

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [REQ_W-1:0] hits;
        for (genvar r = 0; r < REQ_W; r++) begin : g_req
            assign hits[r] = slot_irq_req[r] && (target[r] == 2'(l));
        end
        assign irq_out[l] = |hits;
    end

endmodule

// File: rtl/legacy_irq_autodetect.sv
module legacy_irq_autodetect
    import irqmap_pkg::*;
#(
    parameter int         NUM_SLOTS    = 8,
    parameter int         CFG_AW       = 24,
    parameter int         CFG_DW       = 32,
    parameter logic [7:0] LINE_REG_OFS = 8'h3C
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       variant_sel,
    input  logic [1:0]                 mode_strap,
    input  logic                       cfg_wr_valid,
    input  logic [CFG_AW-1:0]          cfg_wr_addr,
    input  logic [CFG_DW-1:0]          cfg_wr_data,
    input  logic [4*NUM_SLOTS-1:0]     slot_irq_req,
    output logic [3:0]                 irq_out,
    output logic [1:0]                 mode_out
);
    snoop_t    snp;
    map_mode_e mode;

    irqmap_snoop #(
        .CFG_AW      (CFG_AW),
        .CFG_DW      (CFG_DW),
        .LINE_REG_OFS(LINE_REG_OFS)
    ) u_snoop (
        .cfg_wr_valid(cfg_wr_valid),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .variant_sel (variant_sel),
        .snp         (snp)
    );

    irqmap_mode_reg u_mode (
        .clk       (clk),
        .rst       (rst),
        .mode_strap(mode_strap),
        .snp       (snp),
        .mode      (mode)
    );

    irqmap_router #(
        .NUM_SLOTS(NUM_SLOTS)
    ) u_router (
        .mode        (mode),
        .variant_sel (variant_sel),
        .slot_irq_req(slot_irq_req),
        .irq_out     (irq_out)
    );

    assign mode_out = mode;

endmodule

// File: rtl/irqmap_checker.sv
module irqmap_checker #(
    parameter int NUM_SLOTS = 8,
    parameter int CFG_AW    = 24
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   variant_sel,
    input logic                   cfg_wr_valid,
    input logic [CFG_AW-1:0]      cfg_wr_addr,
    input logic [4*NUM_SLOTS-1:0] slot_irq_req,
    input logic [3:0]             irq_out,
    input logic [1:0]             mode_out
);
    logic [3:0] pin_any;

    always_comb begin
        pin_any = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            pin_any = pin_any | slot_irq_req[4*s +: 4];
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode_out != 2'd3);  // R1

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        mode_out != 2'd0 |=> $stable(mode_out));  // R2

    AST_NO_DETECT_ALT_VARIANT: assert property (@(posedge clk) disable iff (rst)
        (variant_sel && mode_out == 2'd0) |=> mode_out == 2'd0);  // R3

    AST_NO_DETECT_OTHER_OFS: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_addr[7:0] != 8'h3C && mode_out == 2'd0) |=> mode_out == 2'd0);  // R3

    AST_NO_DETECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr_valid && mode_out == 2'd0) |=> mode_out == 2'd0);  // R3

    AST_LEGACY_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        mode_out == 2'd1 |-> irq_out == pin_any);  // R7

    AST_QUIET_LINES: assert property (@(posedge clk) disable iff (rst)
        slot_irq_req == '0 |-> irq_out == 4'd0);  // R9

    AST_LINE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_out) <= $countones(slot_irq_req));  // R9

endmodule

bind legacy_irq_autodetect irqmap_checker #(
    .NUM_SLOTS(NUM_SLOTS),
    .CFG_AW   (CFG_AW)
) u_irqmap_checker (
    .clk         (clk),
    .rst         (rst),
    .variant_sel (variant_sel),
    .cfg_wr_valid(cfg_wr_valid),
    .cfg_wr_addr (cfg_wr_addr),
    .slot_irq_req(slot_irq_req),
    .irq_out     (irq_out),
    .mode_out    (mode_out)
);

// File: tb/legacy_irq_autodetect_bench.sv
module legacy_irq_autodetect_bench;

    localparam int NS = 8;
    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          variant_sel = 1'b0;
    logic [1:0]    mode_strap = 2'd0;
    logic          cfg_wr_valid = 1'b0;
    logic [AW-1:0] cfg_wr_addr = '0;
    logic [DW-1:0] cfg_wr_data = '0;
    logic [4*NS-1:0] slot_irq_req = '0;
    logic [3:0]    irq_out;
    logic [1:0]    mode_out;

    int checks = 0;
    int fails  = 0;
    int model_mode = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    legacy_irq_autodetect #(.NUM_SLOTS(NS), .CFG_AW(AW), .CFG_DW(DW)) u_legacy_irq_autodetect (
        .clk(clk), .rst(rst), .variant_sel(variant_sel), .mode_strap(mode_strap),
        .cfg_wr_valid(cfg_wr_valid), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .slot_irq_req(slot_irq_req), .irq_out(irq_out), .mode_out(mode_out)
    );

    // behavioural reference of the mode register
    always @(posedge clk) begin
        if (rst) begin
            model_mode = (mode_strap == 2'd3) ? 0 : int'(mode_strap);
        end else if (model_mode == 0 && cfg_wr_valid && !variant_sel
                     && cfg_wr_addr[7:0] == 8'h3C) begin
            int sl;
            int v;
            sl = int'(cfg_wr_addr[15:11]) % 4;
            v  = int'(cfg_wr_data[7:0]);
            if (v == 27)                          model_mode = (sl == 2) ? 0 : 1;
            else if (v == 27 + sl || v == 91 + sl) model_mode = 1;
            else                                  model_mode = 2;
        end
    end

    function automatic logic [3:0] exp_irq();
        logic [3:0] e = '0;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 4; p++)
                if (slot_irq_req[4*s+p]) begin
                    if (model_mode == 1) e[p] = 1'b1;
                    else e[(s + p + (variant_sel ? 3 : 2)) % 4] = 1'b1;
                end
        return e;
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        checks++;
        if (int'(mode_out) != model_mode) begin
            fails++;
            $display("FAIL %s mode: actual %0d expected %0d", cur_req, mode_out, model_mode);
        end
        if (!rst) begin
            logic [3:0] e;
            e = exp_irq();
            checks++;
            if (irq_out !== e) begin
                fails++;
                $display("FAIL %s irq: actual %b expected %b", cur_req, irq_out, e);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check_mode(input int exp, input string req);
        @(negedge clk);
        #2;
        checks++;
        if (int'(mode_out) != exp) begin
            fails++;
            $display("FAIL %s fixed mode: actual %0d expected %0d", req, mode_out, exp);
        end
        #1;
    endtask

    task automatic do_reset(input logic [1:0] strap);
        step();
        rst = 1'b1;
        mode_strap = strap;
        cfg_wr_valid = 1'b0;
        slot_irq_req = '0;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic cfg_write(input int slot, input logic [7:0] ofs, input logic [DW-1:0] data,
                             input logic valid);
        step();
        cfg_wr_valid = valid;
        cfg_wr_addr  = AW'((slot << 11) | int'(ofs));
        cfg_wr_data  = data;
        step();
        cfg_wr_valid = 1'b0;
    endtask

    task automatic walk_requests();
        for (int b = 0; b < 4 * NS; b++) begin
            step();
            slot_irq_req = '0;
            slot_irq_req[b] = 1'b1;
        end
        step();
        slot_irq_req = '0;
    endtask

    task automatic combo_requests();
        step(); slot_irq_req = 32'h0000_0011;
        step(); slot_irq_req = 32'h8421_0000;
        step(); slot_irq_req = 32'h0F00_F00F;
        step(); slot_irq_req = '1;
        step(); slot_irq_req = 32'h1248_1248;
        step(); slot_irq_req = '0;
    endtask

    initial begin
        // R1: reset state with default strap
        cur_req = "R1";
        do_reset(2'd0);
        check_mode(0, "R1");

        // R8: routing in assume-correct mode, both variants
        cur_req = "R8";
        walk_requests();
        variant_sel = 1'b1;
        walk_requests();
        // R9: shared lines
        cur_req = "R9";
        combo_requests();

        // R3: ignored writes
        cur_req = "R3";
        cfg_write(0, 8'h3C, 32'd28, 1'b1);   // second variant selected
        variant_sel = 1'b0;
        cfg_write(0, 8'h3D, 32'd28, 1'b1);   // wrong offset
        cfg_write(0, 8'h3C, 32'd28, 1'b0);   // strobe low
        check_mode(0, "R3");

        // R5/R4: ambiguous 27 at slots congruent to 2
        cur_req = "R5";
        cfg_write(2, 8'h3C, 32'd27, 1'b1);
        cfg_write(6, 8'h3C, 32'd27, 1'b1);
        check_mode(0, "R5");

        // R6/R4/R10: 27+1 at slot 5 selects legacy
        cur_req = "R6/R10";
        cfg_write(5, 8'h3C, 32'd28, 1'b1);
        check_mode(1, "R6");
        cur_req = "R7";
        walk_requests();
        combo_requests();
        variant_sel = 1'b1;
        walk_requests();
        variant_sel = 1'b0;
        // R2: later writes ignored
        cur_req = "R2";
        cfg_write(0, 8'h3C, 32'hFF, 1'b1);
        cfg_write(1, 8'h3C, 32'd50, 1'b1);
        check_mode(1, "R2");

        // R6: shifted form 91+3 at slot 3
        cur_req = "R6";
        do_reset(2'd0);
        cfg_write(3, 8'h3C, 32'd94, 1'b1);
        check_mode(1, "R6");

        // R5: only low byte counts, 27 at slot 0 selects legacy
        cur_req = "R5";
        do_reset(2'd0);
        cfg_write(0, 8'h3C, 32'h0000_011B, 1'b1);
        check_mode(1, "R5");

        // R4: high slot bits ignored, 29 at slot 4 (mod 0) is not telling -> forced
        cur_req = "R4";
        do_reset(2'd0);
        cfg_write(4, 8'h3C, 32'd29, 1'b1);
        check_mode(2, "R4");
        cur_req = "R8/R10";
        walk_requests();
        variant_sel = 1'b1;
        walk_requests();
        variant_sel = 1'b0;
        cur_req = "R2";
        cfg_write(1, 8'h3C, 32'd27, 1'b1);
        cfg_write(3, 8'h3C, 32'd30, 1'b1);
        check_mode(2, "R2");

        // R1: strap values
        cur_req = "R1";
        do_reset(2'd1);
        check_mode(1, "R1");
        do_reset(2'd2);
        check_mode(2, "R1");
        do_reset(2'd3);
        check_mode(0, "R1");
        combo_requests();

        step();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule